// File: doc/BRIEF.md
# Two-Group Key Matrix Input Register

A memory-mapped input register for eight keys arranged as two groups of four: an action group and a direction pad. Software writes two active-low group-select bits. A read returns the selected groups' key states in a low nibble, where a pressed key reads as 0. When both groups are selected, their nibbles are combined by AND.

Because a direction pad pivots, opposite directions cannot both be pressed. Unless a bypass pin is high, the block removes such combinations with a fixed priority. When neither group is selected, the nibble carries a multiplayer identification value instead.

The nibble is re-evaluated on every clock. A one-cycle interrupt pulse marks each change of the nibble from all-released (0xF) to any other value.

Top module: `key_matrix_reg`

## Requirements
- R1: After reset both select bits are 1, the interrupt output is low and `rd_data` is 0xFF.
- R2: A write stores only `wr_data[5]` and `wr_data[4]` as the action-select and direction-select bits. All other data bits have no effect, and the select bits change only on a write.
- R3: With action-select at 0, the nibble is ANDed with the inverted action keys, mapped as Start bit 3, Select bit 2, B bit 1 and A bit 0 (`act_keys` uses the same positions, 1 = pressed).
- R4: With direction-select at 0, the nibble is ANDed with the inverted direction keys, mapped as Down bit 3, Up bit 2, Left bit 1 and Right bit 0 (`dir_keys` uses the same positions, 1 = pressed).
- R5: With both select bits at 0, the nibble is the bitwise AND of the two inverted groups.
- R6: While `raw_dir` is 0, a pressed Up forces Down to read as released, and a pressed Left forces Right to read as released. While `raw_dir` is 1, all four directions pass unchanged.
- R7: With both select bits at 1, the nibble is 0xF minus `mp_req`. `mp_req` has no effect when either select bit is 0.
- R8: A read strobe in one cycle makes `rd_data` equal to {2'b11, action-select, direction-select, nibble} in the next cycle. This uses the select bits and keys present in the strobe cycle, and the value holds until the next read.
- R9: `irq` is high for exactly one cycle, in the cycle after the first clock edge at which the evaluated nibble is not 0xF while it was 0xF at the edge before. It stays low while the nibble remains non-0xF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| act_keys | input | 4 | Action keys, 1 = pressed (Start, Select, B, A at bits 3..0) |
| dir_keys | input | 4 | Direction keys, 1 = pressed (Down, Up, Left, Right at bits 3..0) |
| raw_dir | input | 1 | 1 = pass opposite directions without filtering |
| mp_req | input | MP_W | Multiplayer value subtracted from 0xF when no group is selected |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data; bits 5 and 4 are the select bits |
| rd_en | input | 1 | Register read strobe |
| rd_data | output | 8 | Read result, registered |
| irq | output | 1 | One-cycle interrupt request pulse |

## Verification
The bench builds the block with its defaults: `MP_W` = 2 and a reset selection of 2'b11. This lets every multiplayer value from 0 to 3 be driven through the idle path and compared against 0xF minus the value. The bench's model is compared with the outputs on every clock. The stimulus covers each of the four selection states, every opposite-direction pair with the bypass pin both low and high, and writes carrying noise in the unused data bits. Interrupt timing is exercised by holding keys pressed across several cycles, by releasing and pressing again, and by changing the selection while keys stay pressed.

// File: rtl/key_matrix_reg.sv
module key_matrix_reg #(
  parameter int MP_W = 2,
  parameter logic [1:0] SEL_RESET = 2'b11
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [3:0]      act_keys,
  input  logic [3:0]      dir_keys,
  input  logic            raw_dir,
  input  logic [MP_W-1:0] mp_req,
  input  logic            wr_en,
  input  logic [7:0]      wr_data,
  input  logic            rd_en,
  output logic [7:0]      rd_data,
  output logic            irq
);
  localparam logic [3:0] IDLE = 4'hF;

  logic [1:0] sel;
  logic [3:0] dir_f;
  logic [3:0] nib;
  logic [3:0] nib_q;
  logic       unused_wr;

  assign unused_wr = ^{wr_data[7:6], wr_data[3:0]};

  assign dir_f[3] = dir_keys[3] & (raw_dir | ~dir_keys[2]);
  assign dir_f[2] = dir_keys[2];
  assign dir_f[1] = dir_keys[1];
  assign dir_f[0] = dir_keys[0] & (raw_dir | ~dir_keys[1]);

  always_comb begin
    nib = IDLE;
    if (sel == 2'b11) nib = IDLE - 4'(mp_req);
    if (!sel[1]) nib = nib & ~act_keys;
    if (!sel[0]) nib = nib & ~dir_f;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel     <= SEL_RESET;
      nib_q   <= IDLE;
      irq     <= 1'b0;
      rd_data <= 8'hFF;
    end else begin
      if (wr_en) sel <= wr_data[5:4];
      nib_q <= nib;
      irq   <= (nib != IDLE) && (nib_q == IDLE);
      if (rd_en) rd_data <= {2'b11, sel, nib};
    end
  end

  p_irq_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  p_irq_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> nib_q != IDLE);
  p_sel_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(sel));
  p_rd_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));
  p_filter_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!raw_dir && sel == 2'b10 && dir_keys[2]) |-> nib[3]);
endmodule

// File: tb/tb_key_matrix_reg.sv
module tb_key_matrix_reg;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] act_keys = '0;
  logic [3:0] dir_keys = '0;
  logic       raw_dir = 1'b0;
  logic [1:0] mp_req = '0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       rd_en = 1'b0;
  logic [7:0] rd_data;
  logic       irq;

  int tests = 0;
  int fails = 0;
  string tag = "R1";

  int m_sel, m_prev, m_irq, m_rd;

  always #5 clk = ~clk;

  key_matrix_reg dut (.*);

  function automatic int mnib(int s, int a, int d, int raw, int mp);
    int dd = d;
    int n = 15;
    if (raw == 0) begin
      if ((dd & 4) != 0) dd = dd & ~8;
      if ((dd & 2) != 0) dd = dd & ~1;
    end
    if (s == 3) n = 15 - mp;
    if ((s & 2) == 0) n = n & ~a & 15;
    if ((s & 1) == 0) n = n & ~dd & 15;
    return n;
  endfunction

  always @(posedge clk) begin
    int n;
    if (!rst_n) begin
      m_sel <= 3; m_prev <= 15; m_irq <= 0; m_rd <= 255;
    end else begin
      n = mnib(m_sel, int'(act_keys), int'(dir_keys), int'(raw_dir), int'(mp_req));
      m_irq  <= (n != 15 && m_prev == 15) ? 1 : 0;
      m_prev <= n;
      if (rd_en) m_rd <= 192 + m_sel * 16 + n;
      if (wr_en) m_sel <= (int'(wr_data) / 16) % 4;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      tests++;
      if (int'(irq) != m_irq) begin
        fails++;
        $display("FAIL R9 irq actual %0d expected %0d", irq, m_irq);
      end
      tests++;
      if (int'(rd_data) != m_rd) begin
        fails++;
        $display("FAIL %s rd_data actual %02h expected %02h", tag, rd_data, m_rd);
      end
    end
  end

  task automatic wr(input logic [7:0] d);
    wr_data = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input string t);
    tag = t; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic keys(input logic [3:0] a, input logic [3:0] d);
    act_keys = a; dir_keys = d;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    tests++;
    if (rd_data !== 8'hFF || irq !== 1'b0) begin
      fails++;
      $display("FAIL R1 reset rd %02h irq %0d expected ff 0", rd_data, irq);
    end
    rd("R1");
    for (int m = 0; m < 4; m++) begin
      mp_req = 2'(m); @(negedge clk); rd("R7");
      repeat (2) @(negedge clk);
    end
    mp_req = 2'd0; repeat (2) @(negedge clk);
    wr(8'hDF); rd("R2");
    mp_req = 2'd3; rd("R7");
    for (int k = 0; k < 16; k++) begin
      keys(4'(k), 4'hF); rd("R3");
    end
    keys(4'h0, 4'h0);
    wr(8'h2F);
    for (int k = 0; k < 16; k++) begin
      raw_dir = 1'b0; keys(4'hF, 4'(k)); rd("R6");
      raw_dir = 1'b1; @(negedge clk); rd("R4");
    end
    raw_dir = 1'b0; keys(4'h0, 4'h0);
    wr(8'hC0);
    keys(4'b1000, 4'b0001); rd("R5");
    keys(4'b0110, 4'b1100); rd("R5");
    keys(4'b0000, 4'b0000); repeat (2) @(negedge clk);
    keys(4'b0001, 4'b0000); repeat (4) @(negedge clk); rd("R9");
    keys(4'b0000, 4'b0000); repeat (2) @(negedge clk);
    keys(4'b0001, 4'b0000); repeat (3) @(negedge clk);
    wr(8'h30); repeat (3) @(negedge clk);
    wr(8'h0F); repeat (3) @(negedge clk);
    wr(8'h10); rd("R2");
    mp_req = 2'd1; wr(8'hFF); repeat (3) @(negedge clk); rd("R7");
    mp_req = 2'd0; wr(8'h10); repeat (2) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++; tests++;
    $display("FAIL R1 watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule